// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Validator

This block sits behind a tone-pair decoder. It turns the decoder's raw "tone seen" detect line into validated digit events. A digit is accepted only after the detect line has stayed high for a programmable number of clock cycles. At that moment the 4-bit decoded code is captured into a receive data register, and a guard output starts to follow the detect line. After a fixed settle delay, a steering flag announces the new digit.

The digit ends only when the detect line has stayed low for a second, independently programmed number of cycles. A shorter low gap is treated as a dropout and is ignored. A host reads the data and status through a 4-bit read port. An optional active-low interrupt follows the steering flag, and a read of the status register acknowledges it.

Both guard times are clock-cycle counts held outside the block and presented on configuration inputs. The settle delay is a parameter.

Top module: `tone_steer_validator`

## Requirements
- R1: A digit is registered on the clock edge at which `detect_i` has been sampled high on PRESENT consecutive edges, where PRESENT is `present_cycles_i`. At that edge `code_i` is captured into the receive data register.
- R2: A high pulse on `detect_i` that lasts fewer than PRESENT edges registers nothing: `guard_o` stays low and the receive data register keeps its value.
- R3: `guard_o` rises on the registration edge. While the digit is active it then repeats `detect_i` one cycle late. It is low whenever no digit is active.
- R4: `steer_flag_o` rises exactly SETTLE_CYCLES edges after the registration edge.
- R5: With `rd_sel_i`=0, `rd_data_o` shows the receive data register. With `rd_sel_i`=1 it shows the status word: bit0 is the steering flag, bit1 is the interrupt pending, bit2 is `guard_o` and bit3 is 0. Reads never change the data register.
- R6: `irq_no` is low exactly while `irq_en_i` is high, `steer_flag_o` is high and the current digit has not been acknowledged.
- R7: A cycle with `rd_en_i`=1 and `rd_sel_i`=1 while the flag is high acknowledges the digit. From the next cycle, `irq_no` is high and status bit1 is 0 until a new digit sets the flag.
- R8: An active digit ends on the edge at which `detect_i` has been sampled low on ABSENT consecutive edges, where ABSENT is `absent_cycles_i`. At that edge `steer_flag_o` clears.
- R9: A low gap shorter than ABSENT does not end the digit. The flag stays high, and no new code is captured while `detect_i` stays high afterwards.
- R10: PRESENT and ABSENT act independently, so either one may be the larger.
- R11: While `rst_ni` is low, the flag, the guard output and the data register are cleared, and `irq_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| detect_i | input | 1 | Raw tone-present detect from the decoder |
| code_i | input | CODE_W | Decoded tone-pair code |
| present_cycles_i | input | GUARD_W | Accept guard time in cycles |
| absent_cycles_i | input | GUARD_W | Pause guard time in cycles |
| irq_en_i | input | 1 | Interrupt mode enable |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | 0 = data register, 1 = status |
| rd_data_o | output | CODE_W | Read data |
| guard_o | output | 1 | Guard-time output |
| steer_flag_o | output | 1 | Delayed steering flag |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A wrong count in the guard counter shows at the ports within one clock cycle: `guard_o` rises one edge too early or too late, or the captured code shows through the data read. A settle counter that is off shifts the edge of `steer_flag_o` and of `irq_no`, which the bench samples on both sides of the expected edge. A counter that is not reset after a dropout shows up as a premature flag clear during a long digit, or as a spurious recapture of a changed code.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  typedef enum logic {ST_IDLE, ST_DIGIT} steer_state_e;
  localparam int unsigned STAT_FLAG = 0;
  localparam int unsigned STAT_PEND = 1;
  localparam int unsigned STAT_GUARD = 2;
endpackage

// File: rtl/tsv_guard.sv
module tsv_guard
  import tsv_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          detect_i,
  input  logic [CW-1:0] present_i,
  input  logic [CW-1:0] absent_i,
  output logic          accept_o,
  output logic          pause_o,
  output logic          active_o,
  output logic          guard_o
);
  steer_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr_p, thr_a;
  logic [CW:0]   cnt_inc;

  // zero guard behaves as one cycle
  assign thr_p   = (present_i == '0) ? CW'(1) : present_i;
  assign thr_a   = (absent_i == '0) ? CW'(1) : absent_i;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  assign accept_o = (st_q == ST_IDLE) && detect_i && (cnt_inc >= {1'b0, thr_p});
  assign pause_o  = (st_q == ST_DIGIT) && !detect_i && (cnt_inc >= {1'b0, thr_a});
  assign active_o = (st_q == ST_DIGIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      guard_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          guard_o <= accept_o;
          if (accept_o) begin
            st_q  <= ST_DIGIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= detect_i ? cnt_inc[CW-1:0] : '0;
          end
        end
        default: begin
          guard_o <= detect_i;
          if (pause_o) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= detect_i ? '0 : cnt_inc[CW-1:0];
          end
        end
      endcase
    end
  end

  assert_guard_in_digit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_o |-> active_o);
  assert_start_on_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(detect_i));
  assert_end_on_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> !$past(detect_i));
endmodule

// File: rtl/tsv_settle.sv
module tsv_settle #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic pause_i,
  output logic flag_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW:0] LIM = (SW + 1)'(SETTLE_CYCLES);

  logic [SW-1:0] scnt_q;
  logic          run_q;
  logic [SW:0]   scnt_inc;

  assign scnt_inc = {1'b0, scnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q <= '0;
      run_q  <= 1'b0;
      flag_o <= 1'b0;
    end else if (pause_i) begin
      run_q  <= 1'b0;
      flag_o <= 1'b0;
      scnt_q <= '0;
    end else if (accept_i) begin
      run_q  <= 1'b1;
      scnt_q <= '0;
    end else if (run_q) begin
      if (scnt_inc >= LIM) begin
        run_q  <= 1'b0;
        flag_o <= 1'b1;
      end else begin
        scnt_q <= scnt_inc[SW-1:0];
      end
    end
  end

  initial assert (SETTLE_CYCLES >= 1);

  assert_flag_after_settle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(run_q) && !$past(accept_i));
  assert_pause_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !flag_o);
endmodule

// File: rtl/tsv_host.sv
module tsv_host
  import tsv_pkg::*;
#(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              flag_i,
  input  logic              guard_i,
  input  logic              irq_en_i,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  output logic [CODE_W-1:0] rd_data_o,
  output logic              irq_no
);
  logic [CODE_W-1:0] data_q;
  logic              ack_q;
  logic              pend;
  logic [CODE_W-1:0] status;

  assign pend  = irq_en_i && flag_i && !ack_q;
  assign irq_no = !pend;

  always_comb begin
    status             = '0;
    status[STAT_FLAG]  = flag_i;
    status[STAT_PEND]  = pend;
    status[STAT_GUARD] = guard_i;
  end

  assign rd_data_o = rd_sel_i ? status : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (accept_i) data_q <= code_i;
      if (!flag_i) ack_q <= 1'b0;
      else if (rd_en_i && rd_sel_i) ack_q <= 1'b1;
    end
  end

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(data_q));
  assert_irq_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> flag_i && irq_en_i);
endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator #(
  parameter int unsigned GUARD_W       = 16,
  parameter int unsigned CODE_W        = 4,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               detect_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [GUARD_W-1:0] present_cycles_i,
  input  logic [GUARD_W-1:0] absent_cycles_i,
  input  logic               irq_en_i,
  input  logic               rd_en_i,
  input  logic               rd_sel_i,
  output logic [CODE_W-1:0]  rd_data_o,
  output logic               guard_o,
  output logic               steer_flag_o,
  output logic               irq_no
);
  logic accept, pause, active;

  tsv_guard #(.CW(GUARD_W)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .detect_i  (detect_i),
    .present_i (present_cycles_i),
    .absent_i  (absent_cycles_i),
    .accept_o  (accept),
    .pause_o   (pause),
    .active_o  (active),
    .guard_o   (guard_o)
  );

  tsv_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .pause_i  (pause),
    .flag_o   (steer_flag_o)
  );

  tsv_host #(.CODE_W(CODE_W)) u_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .code_i    (code_i),
    .flag_i    (steer_flag_o),
    .guard_i   (guard_o),
    .irq_en_i  (irq_en_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .irq_no    (irq_no)
  );

  assert_no_reaccept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_flag_o |-> !accept);
  assert_flag_in_digit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_flag_o |-> active);
endmodule

// File: tb/tone_steer_validator_test.sv
`timescale 1ns/1ps
module tone_steer_validator_test;
  localparam int GW = 16;
  localparam int S  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic detect = 1'b0;
  logic [3:0] code = '0;
  logic [GW-1:0] pres = '0, abs_c = '0;
  logic irq_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [3:0] rd_data;
  logic guard, flag, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tone_steer_validator #(.GUARD_W(GW), .CODE_W(4), .SETTLE_CYCLES(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .detect_i(detect), .code_i(code),
    .present_cycles_i(pres), .absent_cycles_i(abs_c), .irq_en_i(irq_en),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .guard_o(guard), .steer_flag_o(flag), .irq_no(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkv(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int exp_data;
    int pl[4] = '{1, 2, 3, 5};
    int al[4] = '{1, 2, 4, 6};
    exp_data = 0;
    @(negedge clk);
    step(2);
    // R11 reset state
    chkv("R11 flag", int'(flag), 0);
    chkv("R11 guard", int'(guard), 0);
    chkv("R11 irq_no", int'(irq_n), 1);
    rd_sel = 1'b0;
    #0.1 chkv("R11 data", int'(rd_data), 0);
    rst_n = 1'b1;
    step(1);

    foreach (pl[pi]) begin
      foreach (al[ai]) begin
        int p, a, c;
        bit ie;
        p = pl[pi]; a = al[ai];
        c = (p * 3 + a * 5 + 1) & 15;
        ie = p[0];
        pres = GW'(p); abs_c = GW'(a); irq_en = ie;
        rd_sel = 1'b0;

        // R2 too-short high
        if (p > 1) begin
          detect = 1'b1; code = 4'(~c);
          step(p - 1);
          chkv("R2 guard after short high", int'(guard), 0);
          detect = 1'b0;
          step(1);
          chkv("R2 data unchanged", int'(rd_data), exp_data);
          chkv("R2 guard stays low", int'(guard), 0);
        end

        // R1 accept after p high edges
        detect = 1'b1; code = 4'(c);
        step(p - 1);
        chkv("R1 no registration before p", int'(guard), 0);
        step(1);
        code = 4'(c ^ 9);
        chkv("R3 guard rises at registration", int'(guard), 1);
        #0.1 chkv("R1 code latched", int'(rd_data), c);
        exp_data = c;
        chkv("R4 flag low at latch", int'(flag), 0);

        // R4 settle delay
        step(S - 1);
        chkv("R4 flag low before settle", int'(flag), 0);
        step(1);
        chkv("R4 flag high after settle", int'(flag), 1);
        chkv("R6 irq level", int'(irq_n), int'(!ie));
        rd_sel = 1'b1;
        #0.1 chkv("R5 status word", int'(rd_data), 4 + (ie ? 2 : 0) + 1);

        // R7 acknowledge by status read
        if (ie) begin
          rd_en = 1'b1;
          step(1);
          rd_en = 1'b0;
          chkv("R7 irq released", int'(irq_n), 1);
          #0.1 chkv("R7 pending cleared", int'(rd_data[1]), 0);
        end
        rd_sel = 1'b0;
        #0.1 chkv("R5 read keeps data", int'(rd_data), c);

        // R9 dropout shorter than a
        if (a > 1) begin
          detect = 1'b0; code = 4'(c ^ 5);
          step(a - 1);
          chkv("R9 flag held in dropout", int'(flag), 1);
          chkv("R3 guard follows low", int'(guard), 0);
          detect = 1'b1;
          step(1);
          chkv("R3 guard follows high", int'(guard), 1);
          step(p + 2);
          chkv("R9 flag still high", int'(flag), 1);
          #0.1 chkv("R9 no recapture", int'(rd_data), c);
        end

        // R8 pause after a low edges
        detect = 1'b0;
        step(a - 1);
        if (a > 1) chkv("R8 flag held before a", int'(flag), 1);
        step(1);
        chkv("R8 flag clears at a", int'(flag), 0);
        chkv("R10 guard low after pause", int'(guard), 0);
        chkv("R6 irq high idle", int'(irq_n), 1);
        #0.1 chkv("R10 data kept after pause", int'(rd_data), c);
        step(1);
      end
    end
    finish_run();
  end
endmodule